// File: doc/BRIEF.md
# Sector Erase Sequencer with Suspend

This block runs the erase side of a parallel NOR flash command interface. It watches decoded bus writes for the six-write erase command sequence. When the last write selects a sector, the block opens an accumulation window. Within that window, each further sector-select write adds a sector to the erase set and restarts the window. When the window runs out with no new sector added, the erase begins. The erase lasts a set number of microsecond ticks. A sector erase can be suspended and later resumed. A chip erase selects every sector and cannot be suspended.

While a read falls inside the erase set, or while the erase is running, the block supplies the status byte instead of array data. Polling software uses that byte to tell the phases apart: accumulating, erasing, suspended and done. While the erase is suspended, sectors outside the erase set return array data, so the surrounding logic can read and program them. The storage array, the program algorithm and the identification tables are not part of this block.

Top module: `fles_erase_seq`

## Requirements
- R1: An erase starts only after this exact sequence of six writes: 0xAA at command address 0x555, 0x55 at 0x2AA, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, then 0x30 at any address in the target sector. Any write that breaks the sequence returns the decoder to its first step, and no erase starts.
- R2: Command addresses are matched on wr_addr[10:0] only; higher address bits are ignored. The sector number is wr_addr[ADDR_W-1 -: SECT_W].
- R3: After the first sector is selected, erase_busy is high and an accumulation window of ACC_US ticks runs. A 0x30 write inside the window sets that sector's bit in erase_mask and restarts the window. The erase phase begins on the ACC_US-th tick after the last sector was added.
- R4: Inside the accumulation window, a write with data other than 0x30 clears erase_mask, drops erase_busy and returns the block to read-array mode.
- R5: Status bit 3 reads 0 during the accumulation window and 1 during the erase phase and during suspend.
- R6: Status bit 7 reads 0 while erase_busy is high and 1 while suspended. Status bit 6 inverts after every read while erase_busy is high, and holds its value while suspended.
- R7: Status bit 2 inverts after each read whose sector is in erase_mask, and only after such reads. This holds while busy and while suspended.
- R8: A 0xB0 write during a sector erase phase suspends the erase on the next cycle. While suspended, ticks are not counted and erase_mask is kept. A 0x30 write resumes the erase. The erase ends after ERASE_US counted ticks in total.
- R9: The sequence 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x10@0x555 starts a chip erase with every erase_mask bit set and no accumulation window. A 0xB0 write has no effect on a chip erase.
- R10: While suspended, rd_status_sel is 1 for reads of sectors in erase_mask and 0 for other sectors. When rd_status_sel is 0, rd_status reads 0x00. Writes other than 0x30 leave the suspend state and erase_mask unchanged.
- R11: When the erase completes, erase_mask clears, erase_busy drops and reads return array data (rd_status_sel is 0).
- R12: After reset, erase_mask is 0, erase_busy and erase_susp are 0, rd_status_sel is 0 and the status toggle bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Decoded bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 8 | Write data (command byte) |
| rd_en | input | 1 | Decoded bus read strobe, one cycle per read |
| rd_sect | input | SECT_W | Sector number of the read address |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| erase_mask | output | 2**SECT_W | Sectors in the erase set |
| erase_busy | output | 1 | Accumulation window or erase phase active |
| erase_susp | output | 1 | Erase suspended |
| rd_status_sel | output | 1 | Current read returns status instead of array data |
| rd_status | output | 8 | Status byte (bits 7, 6, 3, 2 used) |

## Verification
The assertions assume that wr_en and rd_en are single-cycle strobes that the bus decoder drives at most once per cycle. They also assume that us_tick never arrives in the same cycle as a write. The suspend-versus-count rule would still resolve that case, but the checks on the window length do not cover it. The stimulus keeps every write, read and tick in its own cycle, with idle cycles between ticks. It issues suspend and resume only between ticks, which keeps the bench's counted-tick expectations exact.

// File: rtl/fles_pkg.sv
package fles_pkg;

   typedef enum logic [1:0] {
      ST_READ  = 2'd0,
      ST_ACCUM = 2'd1,
      ST_ERASE = 2'd2,
      ST_SUSP  = 2'd3
   } ers_state_e;

   localparam logic [7:0] CMD_KEY_A    = 8'hAA;
   localparam logic [7:0] CMD_KEY_B    = 8'h55;
   localparam logic [7:0] CMD_ERS_PRE  = 8'h80;
   localparam logic [7:0] CMD_SECT_GO  = 8'h30;
   localparam logic [7:0] CMD_CHIP_GO  = 8'h10;
   localparam logic [7:0] CMD_PAUSE    = 8'hB0;

   localparam int STAT_DONE_BIT  = 7;
   localparam int STAT_TOG_BIT   = 6;
   localparam int STAT_TMR_BIT   = 3;
   localparam int STAT_SECT_BIT  = 2;

endpackage

// File: rtl/fles_unlock_dec.sv
module fles_unlock_dec
   import fles_pkg::*;
#(
   parameter int CMD_AW = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              wr_en,
   input  logic [CMD_AW-1:0] cmd_addr,
   input  logic [7:0]        wr_data,
   output logic              sect_cmd,
   output logic              chip_cmd
);

   localparam logic [CMD_AW-1:0] ADR_HI = CMD_AW'('h555);
   localparam logic [CMD_AW-1:0] ADR_LO = CMD_AW'('h2AA);

   logic [2:0] step_q;
   logic [2:0] step_d;
   logic       key_a;
   logic       key_b;
   logic       pre_ok;
   logic       chip_ok;

   assign key_a   = (cmd_addr == ADR_HI) && (wr_data == CMD_KEY_A);
   assign key_b   = (cmd_addr == ADR_LO) && (wr_data == CMD_KEY_B);
   assign pre_ok  = (cmd_addr == ADR_HI) && (wr_data == CMD_ERS_PRE);
   assign chip_ok = (cmd_addr == ADR_HI) && (wr_data == CMD_CHIP_GO);

   always_comb begin
      step_d   = 3'd0;
      sect_cmd = 1'b0;
      chip_cmd = 1'b0;
      if (enable && wr_en) begin
         case (step_q)
            3'd0: step_d = key_a  ? 3'd1 : 3'd0;
            3'd1: step_d = key_b  ? 3'd2 : 3'd0;
            3'd2: step_d = pre_ok ? 3'd3 : 3'd0;
            3'd3: step_d = key_a  ? 3'd4 : 3'd0;
            3'd4: step_d = key_b  ? 3'd5 : 3'd0;
            3'd5: begin
               step_d   = 3'd0;
               sect_cmd = (wr_data == CMD_SECT_GO);
               chip_cmd = chip_ok;
            end
            default: step_d = 3'd0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q <= 3'd0;
      end else if (!enable) begin
         step_q <= 3'd0;
      end else if (wr_en) begin
         step_q <= step_d;
      end
   end

endmodule

// File: rtl/fles_tick_timer.sv
module fles_tick_timer #(
   parameter int LIMIT = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   input  logic tick,
   output logic hit
);

   localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   assign hit = run && tick && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (run && tick && !hit) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

endmodule

// File: rtl/fles_status_gen.sv
module fles_status_gen
   import fles_pkg::*;
#(
   parameter int SECT_W = 3,
   parameter int N_SECT = 2**SECT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ers_state_e        state,
   input  logic [N_SECT-1:0] mask,
   input  logic              rd_en,
   input  logic [SECT_W-1:0] rd_sect,
   output logic              sel,
   output logic [7:0]        status
);

   logic busy;
   logic held;
   logic in_set;
   logic tog_all_q;
   logic tog_set_q;

   assign busy   = (state == ST_ACCUM) || (state == ST_ERASE);
   assign held   = (state == ST_SUSP);
   assign in_set = mask[rd_sect];
   assign sel    = busy || (held && in_set);

   always_comb begin
      status = 8'h00;
      if (sel) begin
         status[STAT_DONE_BIT] = held;
         status[STAT_TOG_BIT]  = tog_all_q;
         status[STAT_TMR_BIT]  = (state == ST_ERASE) || held;
         status[STAT_SECT_BIT] = tog_set_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tog_all_q <= 1'b0;
         tog_set_q <= 1'b0;
      end else if (rd_en) begin
         if (busy) begin
            tog_all_q <= ~tog_all_q;
         end
         if ((busy || held) && in_set) begin
            tog_set_q <= ~tog_set_q;
         end
      end
   end

endmodule

// File: rtl/fles_erase_seq.sv
module fles_erase_seq
   import fles_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int SECT_W   = 3,
   parameter int CMD_AW   = 11,
   parameter int ACC_US   = 50,
   parameter int ERASE_US = 1000,
   parameter int N_SECT   = 2**SECT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              rd_en,
   input  logic [SECT_W-1:0] rd_sect,
   input  logic              us_tick,
   output logic [N_SECT-1:0] erase_mask,
   output logic              erase_busy,
   output logic              erase_susp,
   output logic              rd_status_sel,
   output logic [7:0]        rd_status
);

   if (SECT_W < 1 || SECT_W > ADDR_W) begin : g_bad_sect
      $error("fles_erase_seq: SECT_W must be in 1..ADDR_W");
   end
   if (CMD_AW < 11 || CMD_AW > ADDR_W) begin : g_bad_cmd
      $error("fles_erase_seq: CMD_AW must be in 11..ADDR_W");
   end
   if (ACC_US < 1 || ERASE_US < 1) begin : g_bad_time
      $error("fles_erase_seq: timer limits must be positive");
   end
   if (N_SECT != 2**SECT_W) begin : g_bad_n
      $error("fles_erase_seq: N_SECT must equal 2**SECT_W");
   end

   ers_state_e        st_q;
   logic              chip_q;
   logic [N_SECT-1:0] mask_q;
   logic [SECT_W-1:0] wr_sect;
   logic              sect_cmd;
   logic              chip_cmd;
   logic              in_read;
   logic              in_accum;
   logic              in_erase;
   logic              add_sect;
   logic              abort_acc;
   logic              pause_req;
   logic              resume_req;
   logic              acc_clr;
   logic              acc_run;
   logic              acc_hit;
   logic              ers_clr;
   logic              ers_run;
   logic              ers_hit;
   logic              mask_clr;
   logic              mask_all;
   logic              mask_add;
   logic              unused_addr_bits;

   assign unused_addr_bits = ^wr_addr;
   assign wr_sect          = wr_addr[ADDR_W-1 -: SECT_W];

   assign in_read  = (st_q == ST_READ);
   assign in_accum = (st_q == ST_ACCUM);
   assign in_erase = (st_q == ST_ERASE);

   fles_unlock_dec #(.CMD_AW(CMD_AW)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (in_read),
      .wr_en    (wr_en),
      .cmd_addr (wr_addr[CMD_AW-1:0]),
      .wr_data  (wr_data),
      .sect_cmd (sect_cmd),
      .chip_cmd (chip_cmd)
   );

   assign add_sect   = in_accum && wr_en && (wr_data == CMD_SECT_GO);
   assign abort_acc  = in_accum && wr_en && (wr_data != CMD_SECT_GO);
   assign pause_req  = in_erase && !chip_q && wr_en && (wr_data == CMD_PAUSE);
   assign resume_req = (st_q == ST_SUSP) && wr_en && (wr_data == CMD_SECT_GO);

   assign acc_clr = (in_read && sect_cmd) || add_sect;
   assign acc_run = in_accum && !wr_en;

   fles_tick_timer #(.LIMIT(ACC_US)) u_acc_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (acc_clr),
      .run   (acc_run),
      .tick  (us_tick),
      .hit   (acc_hit)
   );

   assign ers_clr = (in_read && chip_cmd) || acc_hit;
   assign ers_run = in_erase && !pause_req;

   fles_tick_timer #(.LIMIT(ERASE_US)) u_ers_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ers_clr),
      .run   (ers_run),
      .tick  (us_tick),
      .hit   (ers_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_READ;
         chip_q <= 1'b0;
      end else begin
         case (st_q)
            ST_READ: begin
               if (sect_cmd) begin
                  st_q   <= ST_ACCUM;
                  chip_q <= 1'b0;
               end else if (chip_cmd) begin
                  st_q   <= ST_ERASE;
                  chip_q <= 1'b1;
               end
            end
            ST_ACCUM: begin
               if (abort_acc) begin
                  st_q <= ST_READ;
               end else if (acc_hit) begin
                  st_q <= ST_ERASE;
               end
            end
            ST_ERASE: begin
               if (pause_req) begin
                  st_q <= ST_SUSP;
               end else if (ers_hit) begin
                  st_q <= ST_READ;
               end
            end
            ST_SUSP: begin
               if (resume_req) begin
                  st_q <= ST_ERASE;
               end
            end
            default: st_q <= ST_READ;
         endcase
      end
   end

   assign mask_clr = abort_acc || (ers_hit && !pause_req);
   assign mask_all = in_read && chip_cmd;
   assign mask_add = (in_read && sect_cmd) || add_sect;

   for (genvar gi = 0; gi < N_SECT; gi++) begin : g_sect
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mask_q[gi] <= 1'b0;
         end else if (mask_clr) begin
            mask_q[gi] <= 1'b0;
         end else if (mask_all) begin
            mask_q[gi] <= 1'b1;
         end else if (mask_add && (wr_sect == SECT_W'(gi))) begin
            mask_q[gi] <= 1'b1;
         end
      end
   end

   fles_status_gen #(.SECT_W(SECT_W), .N_SECT(N_SECT)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .state   (st_q),
      .mask    (mask_q),
      .rd_en   (rd_en),
      .rd_sect (rd_sect),
      .sel     (rd_status_sel),
      .status  (rd_status)
   );

   assign erase_mask = mask_q;
   assign erase_busy = in_accum || in_erase;
   assign erase_susp = (st_q == ST_SUSP);

endmodule

// File: rtl/fles_erase_seq_chk.sv
module fles_erase_seq_chk #(
   parameter int N_SECT = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [7:0]        wr_data,
   input logic [N_SECT-1:0] erase_mask,
   input logic              erase_busy,
   input logic              erase_susp,
   input logic              rd_status_sel,
   input logic [7:0]        rd_status,
   input logic              in_accum,
   input logic              chip_mode
);

   // R4: a non-0x30 write in the window empties the set and ends the busy phase
   a_r4_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (in_accum && wr_en && wr_data != 8'h30) |=> (erase_mask == '0 && !erase_busy));

   // R9: suspend request during chip erase is ignored
   a_r9_chip_no_pause: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_mode && erase_busy && !in_accum && wr_en && wr_data == 8'hB0) |=> !erase_susp);

   // R8: busy and suspended never coexist
   a_r8_busy_susp_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(erase_busy && erase_susp));

   // R8: erase set is kept across a suspend cycle
   a_r8_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
      erase_susp |=> (erase_mask == $past(erase_mask)));

   // R11: idle means an empty erase set
   a_r11_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (!erase_busy && !erase_susp) |-> (erase_mask == '0 && !rd_status_sel));

   // R5: timer bit reads 1 on status reads while suspended
   a_r5_susp_tmr_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_susp && rd_status_sel) |-> rd_status[3]);

   // R6: toggle bit 6 is frozen while suspended
   a_r6_tog_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_susp && $past(erase_susp) && rd_status_sel && $past(rd_status_sel))
         |-> (rd_status[6] == $past(rd_status[6])));

   // R10: no status byte when array data is selected
   a_r10_array_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_status_sel |-> (rd_status == 8'h00));

endmodule

bind fles_erase_seq fles_erase_seq_chk #(.N_SECT(N_SECT)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .wr_data       (wr_data),
   .erase_mask    (erase_mask),
   .erase_busy    (erase_busy),
   .erase_susp    (erase_susp),
   .rd_status_sel (rd_status_sel),
   .rd_status     (rd_status),
   .in_accum      (in_accum),
   .chip_mode     (chip_q)
);

// File: tb/tb_fles_erase_seq.sv
module tb_fles_erase_seq;

   localparam int ADDR_W = 16;
   localparam int SECT_W = 3;
   localparam int ACC    = 4;
   localparam int ERS    = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [7:0]        wr_data = '0;
   logic              rd_en = 1'b0;
   logic [SECT_W-1:0] rd_sect = '0;
   logic              us_tick = 1'b0;
   logic [7:0]        erase_mask;
   logic              erase_busy;
   logic              erase_susp;
   logic              rd_status_sel;
   logic [7:0]        rd_status;

   int    checks = 0;
   int    failures = 0;
   bit    finished = 1'b0;
   string cur_req = "R12";

   always #5 clk = ~clk;

   fles_erase_seq #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .CMD_AW(11),
                    .ACC_US(ACC), .ERASE_US(ERS)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_sect(rd_sect), .us_tick(us_tick),
      .erase_mask(erase_mask), .erase_busy(erase_busy), .erase_susp(erase_susp),
      .rd_status_sel(rd_status_sel), .rd_status(rd_status)
   );

   // behavioural reference: 0 read, 1 window, 2 erasing, 3 suspended
   int       m_mode, m_step, m_acc, m_ers;
   bit [7:0] m_set;
   bit       m_chip, m_t6, m_t2;

   always @(posedge clk) begin
      int  old;
      int  ws;
      bit  go_sect, go_chip, act;
      old = m_mode;
      ws  = int'(wr_addr[15:13]);
      if (!rst_n) begin
         m_mode = 0; m_step = 0; m_acc = 0; m_ers = 0;
         m_set = 0; m_chip = 0; m_t6 = 0; m_t2 = 0;
      end else begin
         act = (old == 1) || (old == 2);
         if (rd_en) begin
            if (act) m_t6 = !m_t6;
            if ((act || old == 3) && m_set[rd_sect]) m_t2 = !m_t2;
         end
         go_sect = 0; go_chip = 0;
         if (old != 0) m_step = 0;
         else if (wr_en) begin
            if (m_step == 0 && wr_addr[10:0] == 11'h555 && wr_data == 8'hAA) m_step = 1;
            else if (m_step == 1 && wr_addr[10:0] == 11'h2AA && wr_data == 8'h55) m_step = 2;
            else if (m_step == 2 && wr_addr[10:0] == 11'h555 && wr_data == 8'h80) m_step = 3;
            else if (m_step == 3 && wr_addr[10:0] == 11'h555 && wr_data == 8'hAA) m_step = 4;
            else if (m_step == 4 && wr_addr[10:0] == 11'h2AA && wr_data == 8'h55) m_step = 5;
            else begin
               if (m_step == 5) begin
                  go_sect = (wr_data == 8'h30);
                  go_chip = (wr_addr[10:0] == 11'h555 && wr_data == 8'h10);
               end
               m_step = 0;
            end
         end
         case (old)
            0: if (go_sect) begin
                  m_set = 8'h01 << ws; m_acc = 0; m_mode = 1; m_chip = 0;
               end else if (go_chip) begin
                  m_set = 8'hFF; m_ers = 0; m_mode = 2; m_chip = 1;
               end
            1: if (wr_en) begin
                  if (wr_data == 8'h30) begin m_set[ws] = 1'b1; m_acc = 0; end
                  else begin m_set = 0; m_mode = 0; end
               end else if (us_tick) begin
                  m_acc++;
                  if (m_acc == ACC) begin m_mode = 2; m_ers = 0; end
               end
            2: if (wr_en && wr_data == 8'hB0 && !m_chip) m_mode = 3;
               else if (us_tick) begin
                  m_ers++;
                  if (m_ers == ERS) begin m_set = 0; m_mode = 0; end
               end
            default: if (wr_en && wr_data == 8'h30) m_mode = 2;
         endcase
      end
   end

   task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // every-cycle comparison against the reference
   always @(negedge clk) begin
      bit       e_busy, e_sel;
      bit [7:0] e_stat;
      #3;
      if (rst_n && !finished) begin
         e_busy = (m_mode == 1) || (m_mode == 2);
         e_sel  = e_busy || (m_mode == 3 && m_set[rd_sect]);
         e_stat = 8'h00;
         if (e_sel) e_stat = {(m_mode == 3), m_t6, 2'b00, (m_mode >= 2), m_t2, 2'b00};
         check8({cur_req, " mask"}, erase_mask, m_set);
         check8({cur_req, " busy/susp/sel"}, {5'd0, erase_busy, erase_susp, rd_status_sel},
                {5'd0, e_busy, (m_mode == 3), e_sel});
         check8({cur_req, " status"}, rd_status, e_stat);
      end
   end

   task automatic cyc(bit we, logic [15:0] wa, logic [7:0] wd, bit re, int rs, bit tk);
      @(negedge clk);
      wr_en = we; wr_addr = wa; wr_data = wd;
      rd_en = re; rd_sect = SECT_W'(rs); us_tick = tk;
   endtask

   task automatic wr(logic [15:0] wa, logic [7:0] wd);
      cyc(1, wa, wd, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 0);
   endtask

   task automatic rd(int s);
      cyc(0, 0, 0, 1, s, 0);
      #3;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         cyc(0, 0, 0, 0, 0, 1);
         cyc(0, 0, 0, 0, 0, 0);
      end
   endtask

   task automatic unlock_pre(logic [15:0] hi, logic [15:0] lo);
      wr(hi, 8'hAA); wr(lo, 8'h55); wr(hi, 8'h80);
      wr(hi, 8'hAA); wr(lo, 8'h55);
   endtask

   initial begin
      logic [7:0] s_a;
      repeat (3) @(negedge clk);
      #3;
      cur_req = "R12";
      check8("R12 reset outputs", {erase_mask}, 8'h00);
      check8("R12 reset flags", {5'd0, erase_busy, erase_susp, rd_status_sel}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      // broken sequence: last unlock write carries 0x77
      cur_req = "R1";
      wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
      wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h77); wr(16'h4000, 8'h30);
      #3;
      check8("R1 broken sequence no erase", {7'd0, erase_busy}, 8'h00);

      // aliased command addresses (bits above 10 set)
      cur_req = "R2";
      unlock_pre(16'h1555, 16'h0AAA);
      wr(16'h4000, 8'h30);
      #3;
      check8("R2 aliased addresses start sector 2", erase_mask, 8'h04);
      check8("R1 busy after sequence", {7'd0, erase_busy}, 8'h01);

      cur_req = "R3";
      ticks(2);
      wr(16'hA000, 8'h30);
      #3;
      check8("R3 sector 5 added", erase_mask, 8'h24);
      ticks(ACC - 1);
      rd(2);
      check8("R5 timer bit low in window", {7'd0, rd_status[3]}, 8'h00);
      check8("R3 still in window", {7'd0, erase_busy}, 8'h01);
      cur_req = "R5";
      ticks(1);
      rd(2);
      check8("R5 timer bit high in erase", {7'd0, rd_status[3]}, 8'h01);
      check8("R6 done bit low while busy", {7'd0, rd_status[7]}, 8'h00);

      cur_req = "R6";
      rd(0); s_a = rd_status;
      rd(0);
      check8("R6 bit 6 inverts per read", {7'd0, rd_status[6]}, {7'd0, ~s_a[6]});
      cur_req = "R7";
      check8("R7 bit 2 unchanged by unselected read", {7'd0, rd_status[2]}, {7'd0, s_a[2]});
      rd(5); s_a = rd_status;
      rd(5);
      check8("R7 bit 2 inverts on selected read", {7'd0, rd_status[2]}, {7'd0, ~s_a[2]});

      cur_req = "R8";
      ticks(4);
      wr(16'h0000, 8'hB0);
      #3;
      check8("R8 suspended", {6'd0, erase_busy, erase_susp}, 8'h01);
      cur_req = "R10";
      rd(0);
      check8("R10 unselected sector reads array", {rd_status_sel, rd_status[6:0]}, 8'h00);
      rd(5);
      check8("R6 done bit high in suspend", {7'd0, rd_status[7]}, 8'h01);
      s_a = rd_status;
      rd(5);
      check8("R6 bit 6 frozen in suspend", {7'd0, rd_status[6]}, {7'd0, s_a[6]});
      check8("R7 bit 2 inverts in suspend", {7'd0, rd_status[2]}, {7'd0, ~s_a[2]});
      wr(16'h0010, 8'h5A);
      #3;
      check8("R10 other write ignored", erase_mask, 8'h24);
      check8("R10 still suspended", {7'd0, erase_susp}, 8'h01);
      ticks(20);
      check8("R8 ticks not counted in suspend", {7'd0, erase_susp}, 8'h01);
      wr(16'h0000, 8'h30);
      ticks(ERS - 4 - 1);
      #3;
      check8("R8 not done one tick early", {7'd0, erase_busy}, 8'h01);
      cur_req = "R11";
      ticks(1);
      rd(5);
      check8("R11 mask cleared", erase_mask, 8'h00);
      check8("R11 array data", {6'd0, erase_busy, rd_status_sel}, 8'h00);

      cur_req = "R4";
      unlock_pre(16'h0555, 16'h02AA);
      wr(16'h2000, 8'h30);
      ticks(1);
      wr(16'h6000, 8'h40);
      #3;
      check8("R4 abort clears", {erase_mask}, 8'h00);
      check8("R4 abort idle", {7'd0, erase_busy}, 8'h00);

      cur_req = "R9";
      unlock_pre(16'h0555, 16'h02AA);
      wr(16'h0555, 8'h10);
      #3;
      check8("R9 chip erase all sectors", erase_mask, 8'hFF);
      wr(16'h0000, 8'hB0);
      #3;
      check8("R9 suspend ignored", {6'd0, erase_busy, erase_susp}, 8'h02);
      ticks(ERS);
      #3;
      check8("R11 chip erase done", {erase_mask}, 8'h00);

      repeat (4) @(negedge clk);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         failures++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule